// File: doc/BRIEF.md
# Gamma Entry Slope Encoder

This block sits on the write side of an extrapolating gamma table. It takes two neighbouring curve points, the current one and the next one, each carrying a 16-bit red, green and blue value. From them it builds the pair of 32-bit table words that the display pipe reads. The lookup hardware keeps a 10-bit base value for every entry and rebuilds the values between entries from a small floating-point slope. The encoder therefore reduces each channel to 10 bits with rounding, takes the clamped rise to the next point, and normalises that rise into a 2-bit exponent and a 4-bit mantissa.

The even word carries the low 8 bits of each base. The odd word carries, per channel, the exponent, the mantissa and the top two base bits. A pair can be marked as the last interval of the curve. For that interval the encoder also flags a rise that cannot be represented, because the last table point is not stored anywhere and is implied only by the final slope.

Pairs enter through a valid/ready handshake and leave through a valid/ready handshake. Internally there are two register stages, so one pair can be accepted every cycle while the output side keeps up.

Top module: `gse_slope_encoder`

## Requirements
- R1: Each 16-bit channel value v is reduced to the 10-bit value q = floor((v*1023 + 32767) / 65535), which lies in 0..1023. The even word carries q[7:0] in the channel lane, and bits [1:0] of the odd-word lane carry q[9:8] of the current point.
- R2: The rise of a channel is d = q(next) - q(current), clamped to 0..127. A falling or flat channel therefore encodes mantissa 0 with exponent 3.
- R3: Normalisation starts with exponent 3 and mantissa d. While the mantissa is above 15, the mantissa is shifted right one bit and the exponent is reduced by one. In each odd-word lane the exponent sits in bits [7:6] and the mantissa in bits [5:2].
- R4: Lanes are packed with red in bits [23:16], green in [15:8] and blue in [7:0]. Bits [31:24] of both words are zero.
- R5: outSteep is 1 only if the pair was marked final (inFinal=1) and q(next) - q(current) exceeds 127 on at least one channel. A non-final pair never raises it, and neither does a falling channel. The flag arrives in the same output beat as its words.
- R6: A pair accepted at rising edge k (inValid and inReady both 1) is presented with outValid=1 after edge k+1. Consecutive pairs can be accepted on consecutive edges and come out in order, one per cycle. inReady is 1 whenever outValid is 0.
- R7: While outValid=1 and outReady=0, inReady is 0 and outValid, both words and outSteep hold their values. Once outReady rises, the held result is released and the stalled pairs follow in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An input pair is offered |
| inReady | output | 1 | The encoder takes the offered pair at this edge |
| inFinal | input | 1 | The pair is the last interval of the curve |
| inCurR | input | 16 | Current point, red |
| inCurG | input | 16 | Current point, green |
| inCurB | input | 16 | Current point, blue |
| inNextR | input | 16 | Next point, red |
| inNextG | input | 16 | Next point, green |
| inNextB | input | 16 | Next point, blue |
| outValid | output | 1 | An encoded result is presented |
| outReady | input | 1 | The consumer takes the result at this edge |
| outEvenWord | output | 32 | Low base bits per lane |
| outOddWord | output | 32 | Exponent, mantissa and high base bits per lane |
| outSteep | output | 1 | The final rise is too steep to encode |

## Verification
A pair accepted at edge k is due at the outputs after edge k+1. Each scenario drives inputs at a falling edge and samples at the falling edge that follows edge k+1. It also confirms at the falling edge in between that outValid is still low. In the streaming scenario one pair is driven per cycle, and the result seen at falling edge i is compared with the pair driven two falling edges earlier. In the stall scenario outReady is held low for a full cycle, and the bench confirms at the next falling edge that the words, the flag and inReady have not moved before it lets the queue drain.

// File: rtl/gse_pkg.sv
package gse_pkg;

  // Strobes passed from the pipeline control to the datapath.
  typedef struct packed {
    logic cap1;   // load stage 1 (rounded points and final mark)
    logic cap2;   // load stage 2 (packed words and steep flag)
  } gseStrobe_t;

endpackage

// File: rtl/gse_round.sv
// Round-to-nearest reduction of an IN_W-bit value to LUT_W bits:
// q = floor((v*(2^LUT_W-1) + 2^(IN_W-1)-1) / (2^IN_W-1)).
// The division by 2^IN_W-1 is replaced by an add of the value shifted
// down by IN_W plus one, followed by a shift, which is exact for this range.
module gse_round #(
  parameter int IN_W  = 16,
  parameter int LUT_W = 10
) (
  input  logic [IN_W-1:0]  value,
  output logic [LUT_W-1:0] rounded
);
  localparam int PW   = IN_W + LUT_W + 1;
  localparam int QMAX = (1 << LUT_W) - 1;
  localparam int HALF = (1 << (IN_W - 1)) - 1;

  logic [PW-1:0] scaled;
  logic [PW-1:0] corrected;

  always_comb begin
    scaled    = PW'(value) * PW'(QMAX) + PW'(HALF);
    corrected = scaled + (scaled >> IN_W) + PW'(1);
    rounded   = LUT_W'(corrected >> IN_W);
  end
endmodule

// File: rtl/gse_slope.sv
// Clamped rise between two rounded points, normalised into a small float.
module gse_slope #(
  parameter int LUT_W  = 10,
  parameter int MANT_W = 4,
  parameter int EXP_W  = 2
) (
  input  logic [LUT_W-1:0]  curVal,
  input  logic [LUT_W-1:0]  nxtVal,
  input  logic              isFinal,
  output logic [EXP_W-1:0]  expo,
  output logic [MANT_W-1:0] mant,
  output logic              steep
);
  localparam int STEPS    = (1 << EXP_W) - 1;
  localparam int DW       = MANT_W + STEPS;
  localparam int DMAX     = (1 << DW) - 1;
  localparam int MANT_MAX = (1 << MANT_W) - 1;

  logic [LUT_W:0]  diff;
  logic            falling;
  logic            tooBig;
  logic [DW-1:0]   clamped;

  always_comb begin
    diff    = {1'b0, nxtVal} - {1'b0, curVal};
    falling = diff[LUT_W];
    tooBig  = !falling && (diff[LUT_W-1:0] > LUT_W'(DMAX));
    if (falling)     clamped = '0;
    else if (tooBig) clamped = DW'(DMAX);
    else             clamped = diff[DW-1:0];
    steep = isFinal && tooBig;
  end

  // One unrolled stage per possible exponent decrement.
  logic [DW-1:0]    mStage [STEPS+1];
  logic [EXP_W-1:0] eStage [STEPS+1];

  assign mStage[0] = clamped;
  assign eStage[0] = EXP_W'(STEPS);

  for (genvar g = 0; g < STEPS; g++) begin : g_norm
    logic wide;
    assign wide          = mStage[g] > DW'(MANT_MAX);
    assign mStage[g + 1] = wide ? (mStage[g] >> 1) : mStage[g];
    assign eStage[g + 1] = wide ? (eStage[g] - EXP_W'(1)) : eStage[g];
  end

  assign mant = MANT_W'(mStage[STEPS]);
  assign expo = eStage[STEPS];
endmodule

// File: rtl/gse_ctrl.sv
// Two-stage pipeline control with a global advance.
module gse_ctrl
  import gse_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output gseStrobe_t strobe
);
  logic s1Valid;
  logic s2Valid;
  logic advance;

  assign advance = !s2Valid || outReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else if (advance) begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

  assign inReady     = advance;
  assign outValid    = s2Valid;
  assign strobe.cap1 = advance && inValid;
  assign strobe.cap2 = advance && s1Valid;
endmodule

// File: rtl/gse_datapath.sv
// Rounding (stage 1), slope normalisation and packing (stage 2).
module gse_datapath
  import gse_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int LUT_W  = 10,
  parameter int MANT_W = 4,
  parameter int EXP_W  = 2,
  parameter int NUM_CH = 3,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  gseStrobe_t               strobe,
  input  logic [NUM_CH*IN_W-1:0]   curVec,
  input  logic [NUM_CH*IN_W-1:0]   nxtVec,
  input  logic                     isFinal,
  output logic [WORD_W-1:0]        evenWord,
  output logic [WORD_W-1:0]        oddWord,
  output logic                     steep
);
  localparam int LANE_W  = 8;
  localparam int LANES_W = NUM_CH * LANE_W;

  logic                finalQ;
  logic [LANES_W-1:0]  evenLanes;
  logic [LANES_W-1:0]  oddLanes;
  logic [NUM_CH-1:0]   steepVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           finalQ <= 1'b0;
    else if (strobe.cap1) finalQ <= isFinal;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [LUT_W-1:0]  curRound;
    logic [LUT_W-1:0]  nxtRound;
    logic [LUT_W-1:0]  curQ;
    logic [LUT_W-1:0]  nxtQ;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;

    gse_round #(.IN_W(IN_W), .LUT_W(LUT_W)) u_roundCur (
      .value  (curVec[c*IN_W +: IN_W]),
      .rounded(curRound)
    );

    gse_round #(.IN_W(IN_W), .LUT_W(LUT_W)) u_roundNxt (
      .value  (nxtVec[c*IN_W +: IN_W]),
      .rounded(nxtRound)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        curQ <= '0;
        nxtQ <= '0;
      end else if (strobe.cap1) begin
        curQ <= curRound;
        nxtQ <= nxtRound;
      end
    end

    gse_slope #(.LUT_W(LUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_slope (
      .curVal (curQ),
      .nxtVal (nxtQ),
      .isFinal(finalQ),
      .expo   (expo),
      .mant   (mant),
      .steep  (steepVec[c])
    );

    assign evenLanes[c*LANE_W +: LANE_W] = curQ[LANE_W-1:0];
    assign oddLanes[c*LANE_W +: LANE_W]  = {expo, mant, curQ[LUT_W-1:LANE_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evenWord <= '0;
      oddWord  <= '0;
      steep    <= 1'b0;
    end else if (strobe.cap2) begin
      evenWord <= WORD_W'(evenLanes);
      oddWord  <= WORD_W'(oddLanes);
      steep    <= |steepVec;
    end
  end
endmodule

// File: rtl/gse_slope_encoder.sv
// Thin top: handshake control plus encoding datapath.
module gse_slope_encoder
  import gse_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int LUT_W  = 10,
  parameter int MANT_W = 4,
  parameter int EXP_W  = 2,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inFinal,
  input  logic [IN_W-1:0]   inCurR,
  input  logic [IN_W-1:0]   inCurG,
  input  logic [IN_W-1:0]   inCurB,
  input  logic [IN_W-1:0]   inNextR,
  input  logic [IN_W-1:0]   inNextG,
  input  logic [IN_W-1:0]   inNextB,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outEvenWord,
  output logic [WORD_W-1:0] outOddWord,
  output logic              outSteep
);
  localparam int NUM_CH = 3;

  gseStrobe_t strobe;

  gse_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  // Lane 0 is blue, lane 2 is red.
  gse_datapath #(
    .IN_W  (IN_W),
    .LUT_W (LUT_W),
    .MANT_W(MANT_W),
    .EXP_W (EXP_W),
    .NUM_CH(NUM_CH),
    .WORD_W(WORD_W)
  ) u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .curVec  ({inCurR, inCurG, inCurB}),
    .nxtVec  ({inNextR, inNextG, inNextB}),
    .isFinal (inFinal),
    .evenWord(outEvenWord),
    .oddWord (outOddWord),
    .steep   (outSteep)
  );
endmodule

// File: rtl/gse_checker.sv
module gse_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outEvenWord,
  input logic [31:0] outOddWord,
  input logic        outSteep
);
  // R7: a stalled result holds still
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outEvenWord)
                              && $stable(outOddWord) && $stable(outSteep));

  // R7: no new pair is taken during a stall
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |-> !inReady);

  // R6: an empty output stage always accepts
  assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> inReady);

  // R4: top byte of both words is zero
  assert_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outEvenWord[31:24] == 8'h00 && outOddWord[31:24] == 8'h00);

  // R5: a steep final rise is clamped, so some lane shows exponent 0, mantissa 15
  assert_steep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outSteep |-> outOddWord[23:18] == 6'b001111
                          || outOddWord[15:10] == 6'b001111
                          || outOddWord[7:2] == 6'b001111);

  for (genvar c = 0; c < 3; c++) begin : g_lane
    // R3: any exponent below 3 leaves a mantissa with its top bit set
    assert_norm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      outValid && outOddWord[c*8+6 +: 2] != 2'd3 |-> outOddWord[c*8+5]);

    // R2: a zero rise keeps the starting exponent
    assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      outValid && outOddWord[c*8+2 +: 4] == 4'd0 |-> outOddWord[c*8+6 +: 2] == 2'd3);
  end
endmodule

bind gse_slope_encoder gse_checker i_chk (.*);

// File: tb/test_gse_slope_encoder.sv
module test_gse_slope_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        inFinal = 1'b0;
  logic [15:0] inCurR = '0, inCurG = '0, inCurB = '0;
  logic [15:0] inNextR = '0, inNextG = '0, inNextB = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outEvenWord;
  logic [31:0] outOddWord;
  logic        outSteep;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gse_slope_encoder i_gse_slope_encoder (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inFinal(inFinal), .inCurR(inCurR), .inCurG(inCurG), .inCurB(inCurB),
    .inNextR(inNextR), .inNextG(inNextG), .inNextB(inNextB),
    .outValid(outValid), .outReady(outReady), .outEvenWord(outEvenWord),
    .outOddWord(outOddWord), .outSteep(outSteep)
  );

  // ---- reference model from the requirements ----
  function automatic int r10(int v);
    return (v * 1023 + 32767) / 65535;
  endfunction

  function automatic logic [7:0] oddLane(int c, int n);
    int cq = r10(c);
    int d = r10(n) - cq;
    int e = 3;
    if (d < 0) d = 0;
    if (d > 127) d = 127;
    while (d > 15) begin
      d = d >> 1;
      e = e - 1;
    end
    return {2'(e), 4'(d), 2'(cq >> 8)};
  endfunction

  function automatic logic [31:0] expEven(int cr, int cg, int cb);
    return {8'h00, 8'(r10(cr)), 8'(r10(cg)), 8'(r10(cb))};
  endfunction

  function automatic logic [31:0] expOdd(int cr, int cg, int cb, int nr, int ng, int nb);
    return {8'h00, oddLane(cr, nr), oddLane(cg, ng), oddLane(cb, nb)};
  endfunction

  function automatic logic expSteep(int cr, int cg, int cb, int nr, int ng, int nb, bit fin);
    return fin && ((r10(nr) - r10(cr) > 127) || (r10(ng) - r10(cg) > 127)
                   || (r10(nb) - r10(cb) > 127));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(int cr, int cg, int cb, int nr, int ng, int nb, bit fin);
    inValid = 1'b1;
    inFinal = fin;
    inCurR = 16'(cr); inCurG = 16'(cg); inCurB = 16'(cb);
    inNextR = 16'(nr); inNextG = 16'(ng); inNextB = 16'(nb);
  endtask

  // One pair, checked when due (two edges after it is driven).
  task automatic sendOne(string tag, int cr, int cg, int cb, int nr, int ng, int nb, bit fin);
    @(negedge clk);
    outReady = 1'b1;
    drive(cr, cg, cb, nr, ng, nb, fin);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk({tag, " not yet valid (R6)"}, 32'(outValid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " valid (R6)"}, 32'(outValid), 32'd1);
    chk({tag, " even"}, outEvenWord, expEven(cr, cg, cb));
    chk({tag, " odd"}, outOddWord, expOdd(cr, cg, cb, nr, ng, nb));
    chk({tag, " steep"}, 32'(outSteep), 32'(expSteep(cr, cg, cb, nr, ng, nb, fin)));
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R6 reset outValid", 32'(outValid), 32'd0);
    chk("R6 reset inReady", 32'(inReady), 32'd1);
    chk("R4 reset even", outEvenWord, 32'd0);
    chk("R4 reset odd", outOddWord, 32'd0);
  endtask

  task automatic testBasic();
    sendOne("R1 R4 basic", 16'h1234, 16'h8000, 16'hFFFF, 16'h1A00, 16'h8400, 16'hFFFF, 1'b0);
  endtask

  task automatic testRounding();
    // 32 rounds to 0, 33 rounds to 1, full scale gives 1023
    sendOne("R1 rounding", 32, 33, 16'hFFFF, 32, 33, 16'hFFFF, 1'b1);
    sendOne("R1 midscale", 16'h7FFF, 16'h0040, 16'h00A0, 16'h8000, 16'h0041, 16'h00A1, 1'b0);
  endtask

  task automatic testFalling();
    sendOne("R2 R5 falling final", 16'h9000, 16'hFFFF, 16'h2000, 16'h1000, 16'h0000, 16'h1FC0, 1'b1);
  endtask

  task automatic testExponents();
    // rises of about 5, 20 and 40 codes, then about 100 codes
    sendOne("R3 exponents 3/2/1", 16'h1000, 16'h1000, 16'h1000,
            16'h1000 + 5 * 64, 16'h1000 + 20 * 64, 16'h1000 + 40 * 64, 1'b0);
    sendOne("R3 exponent 0", 16'h2000, 16'h3000, 16'h0400,
            16'h2000 + 100 * 64, 16'h3000 + 64 * 64, 16'h0400 + 16 * 64, 1'b0);
  endtask

  task automatic testSteep();
    sendOne("R5 steep final", 16'h0000, 16'h1000, 16'h1000, 16'h4000, 16'h1000, 16'h1100, 1'b1);
    sendOne("R5 steep not final", 16'h0000, 16'h1000, 16'h1000, 16'h4000, 16'h1000, 16'h1100, 1'b0);
    sendOne("R5 rise 127 final", 0, 0, 0, 8136, 0, 0, 1'b1);
    sendOne("R5 rise 128 final", 0, 0, 0, 0, 8200, 0, 1'b1);
  endtask

  task automatic testStream();
    int cr[6], nr[6], cg[6], ng[6];
    for (int i = 0; i < 6; i++) begin
      cr[i] = 1000 * i + 17;
      nr[i] = cr[i] + 700 * i;
      cg[i] = 60000 - 9000 * i;
      ng[i] = cg[i] + 333 * i - 500;
    end
    outReady = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R6 stream valid", 32'(outValid), 32'd1);
        chk("R6 stream odd", outOddWord, expOdd(cr[i-2], cg[i-2], 16'h0100, nr[i-2], ng[i-2], 16'h0180));
        chk("R6 stream even", outEvenWord, expEven(cr[i-2], cg[i-2], 16'h0100));
      end
      if (i < 6) drive(cr[i], cg[i], 16'h0100, nr[i], ng[i], 16'h0180, 1'b0);
      else inValid = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic testStall();
    @(negedge clk);
    outReady = 1'b0;
    drive(16'h0100, 16'h0200, 16'h0300, 16'h0500, 16'h0200, 16'h0300, 1'b0);  // A
    @(posedge clk);
    @(negedge clk);
    drive(16'h4000, 16'h4000, 16'h4000, 16'h4800, 16'h4000, 16'h3000, 1'b0);  // B
    @(posedge clk);
    @(negedge clk);
    chk("R7 stall valid A", 32'(outValid), 32'd1);
    chk("R7 stall inReady low", 32'(inReady), 32'd0);
    drive(16'h8000, 16'h0000, 16'hF000, 16'h8000, 16'h0100, 16'hF800, 1'b1);  // C
    @(posedge clk);
    @(negedge clk);
    chk("R7 held odd A", outOddWord, expOdd(16'h0100, 16'h0200, 16'h0300, 16'h0500, 16'h0200, 16'h0300));
    chk("R7 held even A", outEvenWord, expEven(16'h0100, 16'h0200, 16'h0300));
    chk("R7 still stalled", 32'(inReady), 32'd0);
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R7 released B", outOddWord, expOdd(16'h4000, 16'h4000, 16'h4000, 16'h4800, 16'h4000, 16'h3000));
    @(posedge clk);
    @(negedge clk);
    chk("R7 released C odd", outOddWord, expOdd(16'h8000, 16'h0000, 16'hF000, 16'h8000, 16'h0100, 16'hF800));
    chk("R7 released C steep", 32'(outSteep), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 drained", 32'(outValid), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testBasic();
    testRounding();
    testFalling();
    testExponents();
    testSteep();
    testStream();
    testStall();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the scenarios finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule